// File: doc/BRIEF.md
# Sixteen-Pin GPIO with Masked Output Writes and a Shared Request Line

This block controls sixteen general-purpose pins through a 32-bit register port. Software sets each pin's direction, updates output values through a write format that names the pins to change, reads back the pin levels, and chooses which upper pins contribute to one shared active-high interrupt request. The levels of the lower eight pins leave the block as a raw vector, so that an interrupt controller elsewhere can give each of them its own input.

A two-bit control register sets the block's state. One bit enables the block's clock and the other holds it in soft reset. After a hardware reset the block is in soft reset with the clock stopped, and it does nothing until software enables it. The usual start-up writes reset-with-clock and then clock-only. The register port is a single-cycle write strobe with an address and data. Reads are combinational from the address.

Top module: `gpio_shared_irq`

## Requirements
- R1: After `rst_n` is released the control register reads 2 (soft reset on, clock off). Direction, output latch, interrupt enable and pin state all read 0, `pad_oe` and `pad_out` are 0, and `shared_irq` and `raw_irq` are 0.
- R2: The direction register is at byte address 0x00. Bit n = 1 makes pin n an output and drives `pad_oe[n]` high. Reads return the 16 bits in 15:0 and zero above.
- R3: A write to the output register at 0x08 changes pin n to data bit n only when mask bit 16+n is 1. Pins whose mask bit is 0 keep their value. `pad_out` shows the latch.
- R4: A read of 0x08 returns the output latch in bits 15:0 and zero in bits 31:16.
- R5: The pin-state register at 0x0C returns `pad_in` through a two-stage synchroniser. A change on `pad_in` first shows after the second rising edge.
- R6: `shared_irq` is 1 exactly when some pin n in 8..15 has both its synchronised level and its interrupt-enable bit at 1.
- R7: The interrupt-enable register at 0x10 is 16 bits wide and reads back in full. Bits 0..7 have no effect on `shared_irq`.
- R8: `raw_irq[n]` equals the synchronised level of pin n for n in 0..7.
- R9: The control register is at 0x14. Bit 0 enables the clock and bit 1 is the soft reset. It is always writable and reads back in bits 1:0.
- R10: While the soft-reset bit is 1, the direction, output and interrupt-enable registers and the pin state are held at 0. Writes to them are ignored and every pin is an input.
- R11: While the clock-enable bit is 0 and soft reset is 0, writes to direction, output and interrupt enable are ignored, and the pin state and `shared_irq` stay frozen even if `pad_in` changes.
- R12: Any other address reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Output latch to the pads |
| pad_oe | output | 16 | Output enable per pin |
| raw_irq | output | 8 | Synchronised levels of pins 0..7 |
| shared_irq | output | 1 | Shared request of pins 8..15 |

## Verification
A corrupted output latch or direction bit shows on `pad_out` or `pad_oe` at the first falling edge after the write, because those ports are the register flops themselves. A synchroniser that is missing a stage, or one that misses the freeze, shows on the pin-state read and on `raw_irq` one edge early, or shows a value that moves while the clock enable is off. A wrong enable slice or reduction shows on `shared_irq` as soon as a lower-pin enable is set or an upper pin rises.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Byte offsets of the registers. Software depends on these values.
  localparam int OFF_DIR  = 'h00;
  localparam int OFF_OUT  = 'h08;
  localparam int OFF_PIN  = 'h0C;
  localparam int OFF_IE   = 'h10;
  localparam int OFF_CTL  = 'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_OUT,
    SEL_PIN,
    SEL_IE,
    SEL_CTL,
    SEL_NONE
  } reg_sel_t;

  // Bit 1 holds the block in soft reset, bit 0 runs its clock.
  typedef struct packed {
    logic soft_rst;
    logic clk_en;
  } blk_ctl_t;

  localparam blk_ctl_t CTL_POWER_ON = '{soft_rst: 1'b1, clk_en: 1'b0};

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  output reg_sel_t      sel
);

  function automatic reg_sel_t decode(input logic [AW-1:0] a);
    reg_sel_t s;
    if      (a == AW'(OFF_DIR)) s = SEL_DIR;
    else if (a == AW'(OFF_OUT)) s = SEL_OUT;
    else if (a == AW'(OFF_PIN)) s = SEL_PIN;
    else if (a == AW'(OFF_IE))  s = SEL_IE;
    else if (a == AW'(OFF_CTL)) s = SEL_CTL;
    else                        s = SEL_NONE;
    return s;
  endfunction

  assign sel = decode(addr);

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_sel_t        sel,
  input  logic [DW-1:0]   wdata,
  output blk_ctl_t        ctl,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] out_q,
  output logic [NPIN-1:0] ie_q
);

  localparam int MASK_LSB = DW / 2;

  // Pins with a set mask bit take the new value; the others keep theirs.
  function automatic logic [NPIN-1:0] merge_masked(
    input logic [NPIN-1:0] old_v,
    input logic [NPIN-1:0] new_v,
    input logic [NPIN-1:0] mask
  );
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  logic [NPIN-1:0] wr_val;
  logic [NPIN-1:0] wr_mask;
  logic            regs_live;
  logic            hit_dir, hit_out, hit_ie, hit_ctl;

  assign wr_val    = wdata[NPIN-1:0];
  assign wr_mask   = wdata[MASK_LSB +: NPIN];
  assign regs_live = ctl.clk_en && !ctl.soft_rst;
  assign hit_dir   = wr_en && (sel == SEL_DIR);
  assign hit_out   = wr_en && (sel == SEL_OUT);
  assign hit_ie    = wr_en && (sel == SEL_IE);
  assign hit_ctl   = wr_en && (sel == SEL_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= CTL_POWER_ON;
    end else if (hit_ctl) begin
      ctl <= blk_ctl_t'(wdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ie_q  <= '0;
    end else if (ctl.soft_rst) begin
      dir_q <= '0;
      out_q <= '0;
      ie_q  <= '0;
    end else if (regs_live) begin
      if (hit_dir) dir_q <= wr_val;
      if (hit_out) out_q <= merge_masked(out_q, wr_val, wr_mask);
      if (hit_ie)  ie_q  <= wr_val;
    end
  end

  assert_ctl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |=> (ctl == blk_ctl_t'($past(wdata[1:0]))));

  assert_soft_rst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.soft_rst |=> (dir_q == '0 && out_q == '0 && ie_q == '0));

  assert_frozen_regs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clk_en && !ctl.soft_rst) |=> ($stable(dir_q) && $stable(out_q) && $stable(ie_q)));

  assert_unmasked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_out && regs_live) |=>
      (((out_q ^ $past(out_q)) & ~$past(wr_mask)) == '0));

  assert_masked_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_out && regs_live) |=>
      (((out_q ^ $past(wr_val)) & $past(wr_mask)) == '0));

  assert_no_stray_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_out && !ctl.soft_rst) |=> $stable(out_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPIN   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            soft_rst,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pin_state
);

  logic [NPIN-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [NPIN-1:0] d_in;
      if (s == 0) begin : g_first
        assign d_in = pad_in;
      end else begin : g_next
        assign d_in = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stage_q[s] <= '0;
        else if (soft_rst) stage_q[s] <= '0;
        else if (clk_en)   stage_q[s] <= d_in;
      end
    end
  endgenerate

  assign pin_state = stage_q[STAGES-1];

  assert_frozen_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !soft_rst) |=> $stable(pin_state));

  assert_soft_rst_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pin_state == '0));

  assert_two_edge_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_en && !soft_rst) ##1 (clk_en && !soft_rst)) |=> (pin_state == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NPIN      = 16,
  parameter int SHARED_LO = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPIN-1:0]           pin_state,
  input  logic [NPIN-1:SHARED_LO]   ie_hi,
  output logic [SHARED_LO-1:0]      raw_irq,
  output logic                      shared_irq
);

  localparam int NSHARED = NPIN - SHARED_LO;

  function automatic logic any_enabled(
    input logic [NSHARED-1:0] lvl,
    input logic [NSHARED-1:0] en
  );
    return |(lvl & en);
  endfunction

  logic [NSHARED-1:0] lvl_hi;

  assign lvl_hi     = pin_state[NPIN-1:SHARED_LO];
  assign shared_irq = any_enabled(lvl_hi, ie_hi);
  assign raw_irq    = pin_state[SHARED_LO-1:0];

  assert_no_enable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_hi == '0) |-> !shared_irq);

  assert_needs_high_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shared_irq |-> (lvl_hi != '0));

  assert_single_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lvl_hi & ie_hi) == 1) |-> shared_irq);

endmodule

// File: rtl/gpio_shared_irq.sv
module gpio_shared_irq
  import gpio_pkg::*;
#(
  parameter int NPIN      = 16,
  parameter int DW        = 32,
  parameter int AW        = 5,
  parameter int SHARED_LO = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NPIN-1:0]      pad_in,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  output logic [SHARED_LO-1:0] raw_irq,
  output logic                 shared_irq
);

  reg_sel_t        sel;
  blk_ctl_t        ctl;
  logic [NPIN-1:0] dir_q, out_q, ie_q, pin_state;

  gpio_addr_dec #(.AW(AW)) dec_i (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_ctrl_regs #(.NPIN(NPIN), .DW(DW)) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr),
    .sel   (sel),
    .wdata (bus_wdata),
    .ctl   (ctl),
    .dir_q (dir_q),
    .out_q (out_q),
    .ie_q  (ie_q)
  );

  gpio_in_sync #(.NPIN(NPIN), .STAGES(2)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (ctl.clk_en),
    .soft_rst  (ctl.soft_rst),
    .pad_in    (pad_in),
    .pin_state (pin_state)
  );

  gpio_irq_merge #(.NPIN(NPIN), .SHARED_LO(SHARED_LO)) irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_state  (pin_state),
    .ie_hi      (ie_q[NPIN-1:SHARED_LO]),
    .raw_irq    (raw_irq),
    .shared_irq (shared_irq)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  always_comb begin
    unique case (sel)
      SEL_DIR: bus_rdata = DW'(dir_q);
      SEL_OUT: bus_rdata = DW'(out_q);
      SEL_PIN: bus_rdata = DW'(pin_state);
      SEL_IE:  bus_rdata = DW'(ie_q);
      SEL_CTL: bus_rdata = DW'(ctl);
      default: bus_rdata = '0;
    endcase
  end

  assert_reset_inputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.soft_rst |=> (pad_oe == '0));

  assert_out_read_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_OUT) |-> (bus_rdata[DW-1:NPIN] == '0));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_shared_irq_tb.sv
module gpio_shared_irq_tb_top;

  localparam int ADR_DIR = 'h00, ADR_OUT = 'h08, ADR_PIN = 'h0C;
  localparam int ADR_IE = 'h10, ADR_CTL = 'h14, ADR_GAP = 'h04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic [7:0]  raw_irq;
  logic        shared_irq;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state kept by the bench
  logic [1:0]  m_ctl = 2'b10;
  logic [15:0] m_dir = '0, m_out = '0, m_ie = '0, m_pin = '0;

  always #10 clk = ~clk;

  gpio_shared_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .raw_irq(raw_irq),
    .shared_irq(shared_irq)
  );

  function automatic logic [15:0] f_merge(input logic [15:0] old_v, input logic [31:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[16+i] ? w[i] : old_v[i];
    return r;
  endfunction

  function automatic logic f_shared(input logic [15:0] pins, input logic [15:0] ie);
    logic r = 1'b0;
    for (int i = 8; i < 16; i++) if (pins[i] && ie[i]) r = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #2;
    d = bus_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    logic [1:0] prev;
    prev = m_ctl;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == ADR_CTL) m_ctl = d[1:0];
    if (prev == 2'b01) begin
      if (a == ADR_DIR) m_dir = d[15:0];
      if (a == ADR_OUT) m_out = f_merge(m_out, d);
      if (a == ADR_IE)  m_ie  = d[15:0];
    end
    if (m_ctl[1]) begin
      m_dir = '0; m_out = '0; m_ie = '0; m_pin = '0;
    end
    if (a == ADR_CTL && m_ctl == 2'b01 && prev != 2'b01) begin
      repeat (2) @(negedge clk);
      m_pin = pad_in;
    end
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (2) @(negedge clk);
    if (m_ctl == 2'b01) m_pin = v;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd(ADR_DIR, d); check({tag, " R2 dir read"}, d, {16'h0, m_dir});
    rd(ADR_OUT, d); check({tag, " R4 out read"}, d, {16'h0, m_out});
    rd(ADR_PIN, d); check({tag, " R5 pin read"}, d, {16'h0, m_pin});
    rd(ADR_IE,  d); check({tag, " R7 ie read"},  d, {16'h0, m_ie});
    rd(ADR_CTL, d); check({tag, " R9 ctl read"}, d, {30'h0, m_ctl});
    check({tag, " R2 pad_oe"},  {16'h0, pad_oe},  {16'h0, m_dir});
    check({tag, " R3 pad_out"}, {16'h0, pad_out}, {16'h0, m_out});
    check({tag, " R8 raw_irq"}, {24'h0, raw_irq}, {24'h0, m_pin[7:0]});
    check({tag, " R6 shared"},  {31'h0, shared_irq}, {31'h0, f_shared(m_pin, m_ie)});
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] hold;
    void'($urandom(32'd1234));
    pad_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: power-on state, pins read zero despite high pads
    check_all("R1 reset");
    // R10: writes ignored while soft reset
    wr(ADR_DIR, 32'h0000_FFFF);
    wr(ADR_OUT, 32'hFFFF_FFFF);
    check_all("R10 reset writes");

    // R9: start-up sequence
    wr(ADR_CTL, 32'h3);
    check_all("R9 ctl=3");
    wr(ADR_CTL, 32'h1);
    check_all("R9 ctl=1");

    // R2: direction with junk in upper bits
    wr(ADR_DIR, 32'hFFFF_A5A5);
    check_all("R2 dir");

    // R3: masked output writes
    wr(ADR_OUT, 32'h00FF_00FF);
    check_all("R3 low set");
    wr(ADR_OUT, 32'h0F00_0000);
    check_all("R3 mask clear");
    wr(ADR_OUT, 32'h0000_FFFF);
    check_all("R3 empty mask");

    // R5: two-edge latency
    set_pins(16'h0000);
    @(negedge clk); pad_in = 16'h1234;
    @(negedge clk); #2 bus_addr = 5'(ADR_PIN); #1;
    check("R5 after one edge", bus_rdata, 32'h0);
    @(negedge clk); #2 bus_addr = 5'(ADR_PIN); #1;
    check("R5 after two edges", bus_rdata, 32'h1234);
    m_pin = 16'h1234;

    // R6/R7/R8: shared request and lower enables
    wr(ADR_IE, 32'h0000_00FF);
    set_pins(16'h00FF);
    check_all("R7 low ie only");
    wr(ADR_IE, 32'h0000_FF00);
    set_pins(16'h0100);
    check_all("R6 pin8 on");
    set_pins(16'h8000);
    check_all("R6 pin15 on");

    // R11: clock stopped freezes everything
    wr(ADR_CTL, 32'h0);
    hold = m_pin;
    wr(ADR_DIR, 32'h0000_0F0F);
    wr(ADR_OUT, 32'hFFFF_0000);
    set_pins(16'h00AA);
    check_all("R11 frozen");
    check("R11 pin hold", {16'h0, m_pin}, {16'h0, hold});

    // R12: unmapped address
    wr(ADR_CTL, 32'h1);
    wr(ADR_GAP, 32'hFFFF_FFFF);
    rd(ADR_GAP, d);
    check("R12 unmapped read", d, 32'h0);
    check_all("R12 after gap write");

    // R10: soft reset with clock stopped
    wr(ADR_CTL, 32'h2);
    check_all("R10 low power");
    wr(ADR_CTL, 32'h3);
    wr(ADR_CTL, 32'h1);

    // Random traffic
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: wr(ADR_DIR, $urandom);
        1: wr(ADR_OUT, $urandom);
        2: wr(ADR_IE,  $urandom);
        default: set_pins(16'($urandom));
      endcase
      check_all("rand R3 R6");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule